// File: doc/BRIEF.md
# Hamming Sector ECC Checker and Corrector

This block takes two 24-bit Hamming check codes for one data sector. One code was read back from storage and one was freshly computed over the data as it arrived. The block decides whether the sector is clean, whether it has a single flipped data bit that can be repaired, whether it has a single flipped bit inside the check code itself, or whether it cannot be repaired. When a data bit can be repaired, the block fixes it in place. It reads the affected byte from the sector buffer RAM, flips the bit and writes the byte back, then signals completion.

Each code enters as three bytes on a 24-bit port, least significant byte in bits 7:0. A one-cycle `in_valid` strobe launches a check. The classification and the decoded location are registered on the strobe edge and held until the next accepted strobe. If a repair is needed, a read-modify-write sequence runs on a synchronous single-port byte RAM interface with one cycle of read latency. `done` pulses once at the end of every check.

Top module: `ecc_sector_fixer`

## Requirements
- R1: Each code is taken with byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. The difference word is the computed code XOR the stored code.
- R2: A zero difference gives status 0 (clean), `fix_en` 0, `err_byte`/`err_bit` 0 and no RAM access, with `done` high in the first cycle after the strobe edge.
- R3: When the upper 12 bits XOR the lower 12 bits of the difference equal 0xFFF and the decoded byte index (difference bits 23:15) is below `SECTOR_BYTES`, the result is status 1 (corrected) with `fix_en` 1. `err_byte` is difference bits 23:15 and `err_bit` is difference bits 14:12.
- R4: When that 0xFFF test passes but the byte index is not below `SECTOR_BYTES`, the result is status 2 (uncorrectable) with `fix_en` 0. `err_byte`/`err_bit` still report the decoded location, and no RAM access takes place.
- R5: A difference with exactly one bit set is a flip inside the code. It gives status 1, `fix_en` 0, location 0, and no RAM access.
- R6: Any other non-zero difference gives status 2, `fix_en` 0 and location 0.
- R7: For a repair, `ram_rd_en` is high with `ram_addr` = `err_byte` in the first cycle after the strobe edge. `ram_wr_en` is high in the third cycle, with `ram_wdata` = read byte XOR (1 << `err_bit`). `done` is high in the fourth cycle.
- R8: The status, location and `fix_en` outputs stay unchanged until the next accepted strobe. A strobe that arrives while a repair is in progress is ignored.
- R9: While reset is applied, `status`, `fix_en`, `done`, `ram_rd_en` and `ram_wr_en` are 0.
- R10: `done` is a single-cycle pulse per check. At most one of `ram_rd_en`, `ram_wr_en` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: launch a check with the present codes |
| calc_code | input | 24 | Freshly computed code, byte 0 in bits 7:0 |
| stored_code | input | 24 | Code read from storage, byte 0 in bits 7:0 |
| status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| err_byte | output | 9 | Decoded byte index of the flipped data bit |
| err_bit | output | 3 | Decoded bit index within that byte |
| fix_en | output | 1 | A data repair applies to this check |
| done | output | 1 | One-cycle end-of-check pulse |
| ram_addr | output | clog2(SECTOR_BYTES) | Buffer RAM byte address |
| ram_rd_en | output | 1 | Buffer RAM read request |
| ram_rdata | input | 8 | Buffer RAM read data, one cycle after the request |
| ram_wr_en | output | 1 | Buffer RAM write request |
| ram_wdata | output | 8 | Buffer RAM write data |

## Verification
A wrong classification shows on `status` and `fix_en` in the first cycle after the strobe. It shows again through the RAM, as a missing write or a write of a byte that gained no repair. A sequencer stuck in the wrong phase shifts the read strobe, write strobe or `done` away from cycles one, three and four, so a timing error is visible within four cycles. A corrupted held result shows as `status` or `err_byte` drifting while no strobe is accepted.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_BAD   = 2'd2
  } ecc_status_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_MODIFY = 3'd2,
    PH_WRITE  = 3'd3,
    PH_FINISH = 3'd4
  } rmw_phase_e;

  localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ecc_diff_decode.sv
module ecc_diff_decode
  import ecc_fix_pkg::*;
#(
  parameter int unsigned HALF_W       = 12,
  parameter int unsigned SECTOR_BYTES = 512,
  localparam int unsigned CODE_W      = 2 * HALF_W,
  localparam int unsigned BYTE_W      = HALF_W - 3
) (
  input  logic [CODE_W-1:0] calc_code,
  input  logic [CODE_W-1:0] stored_code,
  output ecc_status_e       status_o,
  output logic [BYTE_W-1:0] loc_byte,
  output logic [2:0]        loc_bit,
  output logic              need_fix
);

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] upper_half;
  logic [HALF_W-1:0] lower_half;
  logic              pair_ok;
  logic              in_range;
  logic              lone_bit;
  logic [BYTE_W-1:0] idx;

  always_comb begin
    diff       = calc_code ^ stored_code;
    upper_half = diff[CODE_W-1:HALF_W];
    lower_half = diff[HALF_W-1:0];
    pair_ok    = (upper_half ^ lower_half) == {HALF_W{1'b1}};
    idx        = upper_half[HALF_W-1:3];
    in_range   = 32'(idx) < SECTOR_BYTES;
    lone_bit   = $onehot(diff);

    status_o = ST_BAD;
    loc_byte = '0;
    loc_bit  = '0;
    need_fix = 1'b0;

    if (diff == '0) begin
      status_o = ST_CLEAN;
    end else if (pair_ok) begin
      loc_byte = idx;
      loc_bit  = upper_half[2:0];
      if (in_range) begin
        status_o = ST_FIXED;
        need_fix = 1'b1;
      end
    end else if (lone_bit) begin
      status_o = ST_FIXED;
    end
  end

  // R3/R4: a repair request only ever comes with the corrected status
  always_comb begin
    a_r3_fix_implies_fixed: assert (!need_fix || status_o == ST_FIXED);
  end

endmodule

// File: rtl/ecc_result_hold.sv
module ecc_result_hold
  import ecc_fix_pkg::*;
#(
  parameter int unsigned BYTE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  ecc_status_e       status_d,
  input  logic [BYTE_W-1:0] byte_d,
  input  logic [2:0]        bit_d,
  input  logic              fix_d,
  output ecc_status_e       status_q,
  output logic [BYTE_W-1:0] byte_q,
  output logic [2:0]        bit_q,
  output logic              fix_q
);

  ecc_status_e       status_n;
  logic [BYTE_W-1:0] byte_n;
  logic [2:0]        bit_n;
  logic              fix_n;

  always_comb begin
    status_n = status_q;
    byte_n   = byte_q;
    bit_n    = bit_q;
    fix_n    = fix_q;
    if (load) begin
      status_n = status_d;
      byte_n   = byte_d;
      bit_n    = bit_d;
      fix_n    = fix_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= ST_CLEAN;
      byte_q   <= '0;
      bit_q    <= '0;
      fix_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      byte_q   <= byte_n;
      bit_q    <= bit_n;
      fix_q    <= fix_n;
    end
  end

  // R8: without a load the held result does not move
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(status_q) && $stable(byte_q) && $stable(bit_q) && $stable(fix_q)));

endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import ecc_fix_pkg::*;
#(
  parameter int unsigned BYTE_W       = 9,
  parameter int unsigned SECTOR_BYTES = 512,
  localparam int unsigned ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 need_fix,
  input  logic [BYTE_W-1:0]    loc_byte,
  input  logic [2:0]           loc_bit,
  input  logic [BYTE_BITS-1:0] ram_rdata,
  output logic                 accept,
  output logic [ADDR_W-1:0]    ram_addr,
  output logic                 ram_rd_en,
  output logic                 ram_wr_en,
  output logic [BYTE_BITS-1:0] ram_wdata,
  output logic                 done
);

  rmw_phase_e           phase_q;
  rmw_phase_e           phase_d;
  logic [BYTE_BITS-1:0] wdata_q;
  logic [BYTE_BITS-1:0] wdata_d;
  logic                 wdata_en;
  logic [BYTE_BITS-1:0] flip_mask;

  always_comb begin
    accept = (phase_q == PH_IDLE) || (phase_q == PH_FINISH);
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE, PH_FINISH: begin
        if (in_valid) phase_d = need_fix ? PH_READ : PH_FINISH;
        else          phase_d = PH_IDLE;
      end
      PH_READ:   phase_d = PH_MODIFY;
      PH_MODIFY: phase_d = PH_WRITE;
      PH_WRITE:  phase_d = PH_FINISH;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    flip_mask = {{(BYTE_BITS-1){1'b0}}, 1'b1} << loc_bit;
    wdata_en  = (phase_q == PH_MODIFY);
    wdata_d   = ram_rdata ^ flip_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (wdata_en) wdata_q <= wdata_d;
    end
  end

  assign ram_addr  = loc_byte[ADDR_W-1:0];
  assign ram_rd_en = (phase_q == PH_READ);
  assign ram_wr_en = (phase_q == PH_WRITE);
  assign ram_wdata = wdata_q;
  assign done      = (phase_q == PH_FINISH);

  // R7: a write always follows its read by exactly two cycles
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> $past(ram_rd_en, 2));

  // R7: written byte is the byte read back with one bit flipped
  a_r7_write_data: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |-> (ram_wdata == ($past(ram_rdata) ^ flip_mask)));

  // R4: the RAM is never addressed outside the sector
  a_r4_addr_in_sector: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd_en || ram_wr_en) |-> (32'(ram_addr) < SECTOR_BYTES));

  // R10: read, write and done never overlap
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_rd_en, ram_wr_en, done}));

  // R7: done after a repair comes one cycle after the write
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en |=> done);

endmodule

// File: rtl/ecc_sector_fixer.sv
module ecc_sector_fixer
  import ecc_fix_pkg::*;
#(
  parameter int unsigned HALF_W       = 12,
  parameter int unsigned SECTOR_BYTES = 512,
  localparam int unsigned CODE_W      = 2 * HALF_W,
  localparam int unsigned BYTE_W      = HALF_W - 3,
  localparam int unsigned ADDR_W      = $clog2(SECTOR_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [CODE_W-1:0]    calc_code,
  input  logic [CODE_W-1:0]    stored_code,
  output logic [1:0]           status,
  output logic [BYTE_W-1:0]    err_byte,
  output logic [2:0]           err_bit,
  output logic                 fix_en,
  output logic                 done,
  output logic [ADDR_W-1:0]    ram_addr,
  output logic                 ram_rd_en,
  input  logic [BYTE_BITS-1:0] ram_rdata,
  output logic                 ram_wr_en,
  output logic [BYTE_BITS-1:0] ram_wdata
);

  logic              rst_core_n;
  ecc_status_e       dec_status;
  logic [BYTE_W-1:0] dec_byte;
  logic [2:0]        dec_bit;
  logic              dec_fix;
  logic              accept;
  logic              load;
  ecc_status_e       held_status;

  ecc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ecc_diff_decode #(
    .HALF_W       (HALF_W),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) i_decode (
    .calc_code   (calc_code),
    .stored_code (stored_code),
    .status_o    (dec_status),
    .loc_byte    (dec_byte),
    .loc_bit     (dec_bit),
    .need_fix    (dec_fix)
  );

  assign load = in_valid && accept;

  ecc_result_hold #(.BYTE_W(BYTE_W)) i_hold (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (load),
    .status_d (dec_status),
    .byte_d   (dec_byte),
    .bit_d    (dec_bit),
    .fix_d    (dec_fix),
    .status_q (held_status),
    .byte_q   (err_byte),
    .bit_q    (err_bit),
    .fix_q    (fix_en)
  );

  ecc_rmw_ctrl #(
    .BYTE_W       (BYTE_W),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) i_rmw (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (in_valid),
    .need_fix  (dec_fix),
    .loc_byte  (err_byte),
    .loc_bit   (err_bit),
    .ram_rdata (ram_rdata),
    .accept    (accept),
    .ram_addr  (ram_addr),
    .ram_rd_en (ram_rd_en),
    .ram_wr_en (ram_wr_en),
    .ram_wdata (ram_wdata),
    .done      (done)
  );

  assign status = held_status;

  // R5/R6: the RAM is only written for a check that reported a repair
  a_r5_write_only_when_fixing: assert property (@(posedge clk) disable iff (!rst_core_n)
    ram_wr_en |-> (fix_en && held_status == ST_FIXED));

  // R2: a clean result never carries a location
  a_r2_clean_no_location: assert property (@(posedge clk) disable iff (!rst_core_n)
    (held_status == ST_CLEAN) |-> (!fix_en && err_byte == '0 && err_bit == '0));

endmodule

// File: tb/test_ecc_sector_fixer.sv
module test_ecc_sector_fixer;

  localparam int SECT   = 384;
  localparam int NVEC   = 10;
  localparam int ADDR_W = $clog2(SECT);

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic [23:0]       calc_code;
  logic [23:0]       stored_code;
  logic [1:0]        status;
  logic [8:0]        err_byte;
  logic [2:0]        err_bit;
  logic              fix_en;
  logic              done;
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_rd_en;
  logic [7:0]        ram_rdata;
  logic              ram_wr_en;
  logic [7:0]        ram_wdata;

  logic [7:0] mem [SECT];
  int         wr_cnt;
  int         n_checks;
  int         n_errors;

  // computed code, stored code, status, byte, bit, repair
  localparam logic [23:0] V_CALC [NVEC] = '{
    24'h5A5A5A, 24'h108B82, 24'hFFF000, 24'hBFF400, 24'hC0A9AA,
    24'hFFF000, 24'h777776, 24'h800000, 24'h000003, 24'h123456};
  localparam logic [23:0] V_STOR [NVEC] = '{
    24'h5A5A5A, 24'h123456, 24'hFFFFFF, 24'h000000, 24'h00AA55,
    24'h000000, 24'h777777, 24'h000000, 24'h000000, 24'h000000};
  localparam logic [1:0] V_ST [NVEC] = '{
    2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd1, 2'd1, 2'd2, 2'd2};
  localparam logic [8:0] V_BYTE [NVEC] = '{
    9'd0, 9'd5, 9'd0, 9'd383, 9'd384, 9'd511, 9'd0, 9'd0, 9'd0, 9'd0};
  localparam logic [2:0] V_BIT [NVEC] = '{
    3'd0, 3'd3, 3'd0, 3'd7, 3'd0, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0};
  localparam logic V_FIX [NVEC] = '{
    1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam string V_REQ [NVEC] = '{
    "R2", "R3", "R3", "R3", "R4", "R4", "R5", "R5", "R6", "R6"};

  ecc_sector_fixer #(.SECTOR_BYTES(SECT)) i_ecc_sector_fixer (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .calc_code (calc_code), .stored_code (stored_code),
    .status (status), .err_byte (err_byte), .err_bit (err_bit),
    .fix_en (fix_en), .done (done), .ram_addr (ram_addr),
    .ram_rd_en (ram_rd_en), .ram_rdata (ram_rdata),
    .ram_wr_en (ram_wr_en), .ram_wdata (ram_wdata));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (ram_rd_en) ram_rdata <= mem[ram_addr];
    if (ram_wr_en) begin
      mem[ram_addr] <= ram_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [23:0] c, input logic [23:0] s,
                         input logic [1:0] est, input logic [8:0] eb,
                         input logic [2:0] ebit, input logic efix,
                         input string req);
    logic [7:0] orig;
    int w0, cyc, rd_cyc, wr_cyc;
    orig = efix ? mem[eb] : 8'h00;
    w0 = wr_cnt;
    @(negedge clk);
    calc_code = c; stored_code = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 1; rd_cyc = 0; wr_cyc = 0;
    while (!done && cyc < 12) begin
      if (ram_rd_en) begin
        rd_cyc = cyc;
        chk(ram_addr == eb[ADDR_W-1:0], "R7", "read address", int'(ram_addr), int'(eb));
      end
      if (ram_wr_en) wr_cyc = cyc;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == (efix ? 4 : 1), req, "done cycle", cyc, efix ? 4 : 1);
    chk(status == est, req, "status", int'(status), int'(est));
    chk(err_byte == eb, req, "err_byte", int'(err_byte), int'(eb));
    chk(err_bit == ebit, req, "err_bit", int'(err_bit), int'(ebit));
    chk(fix_en == efix, req, "fix_en", int'(fix_en), int'(efix));
    chk(wr_cnt - w0 == (efix ? 1 : 0), req, "RAM writes", wr_cnt - w0, efix ? 1 : 0);
    if (efix) begin
      chk(rd_cyc == 1, "R7", "read cycle", rd_cyc, 1);
      chk(wr_cyc == 3, "R7", "write cycle", wr_cyc, 3);
      chk(mem[eb] == (orig ^ (8'h01 << ebit)), "R7", "repaired byte",
          int'(mem[eb]), int'(orig ^ (8'h01 << ebit)));
    end
    @(negedge clk);
    chk(!done, "R10", "done width", int'(done), 0);
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [7:0] orig;
    n_checks = 0; n_errors = 0; wr_cnt = 0;
    in_valid = 1'b0; calc_code = '0; stored_code = '0; ram_rdata = '0;
    for (int i = 0; i < SECT; i++) mem[i] = 8'(i * 7 + 3);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(status == 2'd0, "R9", "status in reset", int'(status), 0);
    chk(!fix_en, "R9", "fix_en in reset", int'(fix_en), 0);
    chk(!done, "R9", "done in reset", int'(done), 0);
    chk(!ram_rd_en && !ram_wr_en, "R9", "RAM strobes in reset",
        int'({ram_rd_en, ram_wr_en}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1..R6: table of code pairs
    for (int i = 0; i < NVEC; i++)
      run_vec(V_CALC[i], V_STOR[i], V_ST[i], V_BYTE[i], V_BIT[i], V_FIX[i], V_REQ[i]);

    // R8: strobe during a repair is ignored; result then held
    orig = mem[10];
    @(negedge clk);
    calc_code = 24'h051FAE; stored_code = 24'h000000; in_valid = 1'b1;
    @(negedge clk);
    calc_code = 24'h000000; stored_code = 24'h000000;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done, "R8", "done after busy strobe", int'(done), 1);
    chk(status == 2'd1, "R8", "status after busy strobe", int'(status), 1);
    chk(err_byte == 9'd10, "R8", "byte after busy strobe", int'(err_byte), 10);
    chk(mem[10] == (orig ^ 8'h02), "R8", "busy repair byte", int'(mem[10]), int'(orig ^ 8'h02));
    repeat (5) @(negedge clk);
    chk(status == 2'd1 && err_byte == 9'd10 && err_bit == 3'd1 && fix_en,
        "R8", "held result", int'(status), 1);
    chk(!done, "R10", "no extra done", int'(done), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule